// File: doc/BRIEF.md
# SDRAM Line-Fill Burst Read Sequencer

This block runs one cache-line refill from a synchronous DRAM when the CPU misses in its cache. A request brings the byte address that missed, a flag for a 16-bit or a 32-bit data bus, and three small timing fields: the wait from row open to the first column command, the CAS latency, and the precharge length. The block then opens the row, waits, and issues one read column command per clock. It captures the returning data, and finally closes the row with a precharge.

The burst always covers one 16-byte aligned line. The first word fetched is the one that missed. The rest of the line follows in wraparound order, so only the column address bits below bit 4 change during the burst. A 32-bit bus takes four beats and a 16-bit bus takes eight. A bus strobe goes low on every clock in which data is on the DRAM bus. Each captured word comes back to the requester with a valid pulse and the address it came from. A done pulse ends the cycle, and a ready signal holds off new requests until then.

Top module: `sdram_burst_rd`

## Requirements
- R1: After reset, req_ready is 1. sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n and sd_bs_n are 1, sd_dqm is all ones, and rd_valid and rd_done are 0.
- R2: A request is taken at a clock edge where req_valid and req_ready are both 1. From the next cycle, req_ready is 0 up to and including the done cycle, and requests presented in that time have no effect on any output. req_ready returns to 1 in the cycle after done.
- R3: In the cycle after acceptance, the block issues row activate: sd_cs_n=0, sd_ras_n=0, sd_cas_n=1, sd_we_n=1. sd_addr carries the request address shifted right by ROW_SHIFT (12).
- R4: Between the activate and the first column command there are exactly req_rcd (0 to 3) no-operation cycles: sd_cs_n=0 and the other command pins 1.
- R5: The block issues 4 read column commands when req_bus16=0 and 8 when req_bus16=1. They fall in consecutive cycles, each with sd_cas_n=0, sd_ras_n=1 and sd_we_n=1.
- R6: Let A be the request address. Beat i uses byte offset ((A[3:2]+i) mod 4)*4 on a 32-bit bus and ((A[3:1]+i) mod 8)*2 on a 16-bit bus. The column command drives sd_addr = {A[11:4], offset}, and the returned rd_addr is {A[25:4], offset}.
- R7: The data cycle for each beat comes L cycles after its column command. L is req_cl, with the value 0 treated as 1. rd_valid is 1 in the cycle after each data cycle and 0 at all other times.
- R8: sd_bs_n is 0 in every data cycle and 1 otherwise. sd_dqm is 0 from the first column command through the last data cycle and all ones otherwise.
- R9: rd_data is sd_dq sampled at the end of the data cycle. In 16-bit mode it is sd_dq[15:0] with the upper half forced to zero.
- R10: After the last data cycle come P precharge-phase cycles. P is req_tpc, with 0 treated as 1. The first of these carries the precharge command (sd_ras_n=0, sd_we_n=0, sd_cas_n=1). Any further ones are no-operation, and sd_cs_n stays 0 throughout.
- R11: rd_done is a single-cycle pulse in the cycle after the last precharge-phase cycle. sd_cs_n is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Line-fill request |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 26 | Byte address of the missed word |
| req_bus16 | input | 1 | 1 selects a 16-bit data bus, 0 a 32-bit one |
| req_rcd | input | 2 | Wait cycles from row activate to first column command |
| req_cl | input | 2 | CAS latency, 0 acts as 1 |
| req_tpc | input | 2 | Precharge-phase cycles, 0 acts as 1 |
| sd_cs_n | output | 1 | DRAM chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable, high for reads |
| sd_dqm | output | 4 | Byte masks, low while the burst runs |
| sd_addr | output | 26 | Multiplexed row or column address |
| sd_dq | input | 32 | DRAM read data |
| sd_bs_n | output | 1 | Bus strobe, low in every data cycle |
| rd_valid | output | 1 | Returned word valid |
| rd_addr | output | 26 | Byte address of the returned word |
| rd_data | output | 32 | Returned word |
| rd_done | output | 1 | Line fill finished |

## Verification
Take the acceptance edge as time zero, and let W = req_rcd, N the beat count, L the clamped latency and P the clamped precharge length. Activate is due in cycle 0. Column command i is due in cycle 1+W+i, its data cycle in cycle 1+W+L+i, and its rd_valid one cycle after that. The precharge command is due in cycle 1+W+N+L, done in cycle 1+W+N+L+P, and ready one cycle later. The bench derives this whole timeline from the request fields and compares every output against it once per clock, on the falling edge. Read data is driven onto sd_dq only in the expected data cycles and garbage is driven elsewhere, so a capture taken in the wrong cycle shows up as a data mismatch.

// File: rtl/sdrb_pkg.sv
package sdrb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_WAIT,
        ST_BURST,
        ST_PRE,
        ST_DONE
    } seq_state_t;

    // a zero setting of a 2-bit timing field behaves as one
    function automatic logic [1:0] at_least_one(input logic [1:0] v);
        return (v == 2'd0) ? 2'd1 : v;
    endfunction

endpackage

// File: rtl/sdrb_wrap.sv
// Critical-word-first offset inside one line for a given beat number.
module sdrb_wrap #(
    parameter int LINE_BYTES = 16,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int BEAT_W = OFF_W - 1
) (
    input  logic [BEAT_W-1:0] start_hi,   // start address bits [OFF_W-1:1]
    input  logic              bus16,
    input  logic [BEAT_W-1:0] beat,
    output logic [OFF_W-1:0]  off
);

    logic [OFF_W-3:0] word_idx;
    logic [OFF_W-2:0] half_idx;

    always_comb begin
        word_idx = start_hi[BEAT_W-1:1] + beat[BEAT_W-2:0];
        half_idx = start_hi + beat;
        off      = bus16 ? {half_idx, 1'b0} : {word_idx, 2'b00};
    end

endmodule

// File: rtl/sdrb_ctrl.sv
// Sequencing state machine, command decode and data capture.
module sdrb_ctrl
    import sdrb_pkg::*;
#(
    parameter int ADDR_W     = 26,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int ROW_SHIFT  = 12,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int BEAT_W = OFF_W - 1,
    localparam int DQM_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_bus16,
    input  logic [1:0]        req_rcd,
    input  logic [1:0]        req_cl,
    input  logic [1:0]        req_tpc,
    output logic [BEAT_W-1:0] start_hi,
    output logic              bus16,
    output logic [BEAT_W-1:0] cas_beat,
    output logic [BEAT_W-1:0] dat_beat,
    input  logic [OFF_W-1:0]  cas_off,
    input  logic [OFF_W-1:0]  dat_off,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic [ADDR_W-1:0] sd_addr,
    input  logic [DATA_W-1:0] sd_dq,
    output logic              sd_bs_n,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_done
);

    localparam int CNT_W  = $clog2(LINE_BYTES / 2 + 4);
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        seq_state_t        st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              bus16;
        logic [1:0]        rcd;
        logic [1:0]        cl;
        logic [1:0]        tpc;
        logic              vld;
        logic [ADDR_W-1:0] vaddr;
        logic [DATA_W-1:0] vdata;
    } seq_regs_t;

    seq_regs_t q, d;

    logic [CNT_W-1:0] nbeat_w, lat_w, burst_last, dat_cnt;
    logic             cas_on, dat_on, pre_cmd;

    // ---- decode of the current state ----
    always_comb begin
        nbeat_w    = q.bus16 ? CNT_W'(LINE_BYTES / 2) : CNT_W'(LINE_BYTES / 4);
        lat_w      = CNT_W'(q.cl);
        burst_last = nbeat_w + lat_w - CNT_W'(1);
        cas_on     = (q.st == ST_BURST) && (q.cnt < nbeat_w);
        dat_on     = (q.st == ST_BURST) && (q.cnt >= lat_w);
        pre_cmd    = (q.st == ST_PRE) && (q.cnt == '0);
        dat_cnt    = q.cnt - lat_w;
    end

    assign start_hi = q.addr[OFF_W-1:1];
    assign bus16    = q.bus16;
    assign cas_beat = q.cnt[BEAT_W-1:0];
    assign dat_beat = dat_cnt[BEAT_W-1:0];

    assign req_ready = (q.st == ST_IDLE);
    assign sd_cs_n   = (q.st == ST_IDLE) || (q.st == ST_DONE);
    assign sd_ras_n  = !((q.st == ST_ACT) || pre_cmd);
    assign sd_cas_n  = !cas_on;
    assign sd_we_n   = !pre_cmd;
    assign sd_dqm    = (q.st == ST_BURST) ? '0 : '1;
    assign sd_bs_n   = !dat_on;
    assign rd_valid  = q.vld;
    assign rd_addr   = q.vaddr;
    assign rd_data   = q.vdata;
    assign rd_done   = (q.st == ST_DONE);

    always_comb begin
        sd_addr = '0;
        if (q.st == ST_ACT)
            sd_addr = ADDR_W'(q.addr[ADDR_W-1:ROW_SHIFT]);
        else if (cas_on)
            sd_addr = ADDR_W'({q.addr[ROW_SHIFT-1:OFF_W], cas_off});
    end

    // ---- next state ----
    always_comb begin
        d       = q;
        d.vld   = dat_on;
        if (dat_on) begin
            d.vaddr = {q.addr[ADDR_W-1:OFF_W], dat_off};
            d.vdata = q.bus16 ? {{(DATA_W-HALF_W){1'b0}}, sd_dq[HALF_W-1:0]} : sd_dq;
        end
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_ACT;
                    d.cnt   = '0;
                    d.addr  = req_addr;
                    d.bus16 = req_bus16;
                    d.rcd   = req_rcd;
                    d.cl    = at_least_one(req_cl);
                    d.tpc   = at_least_one(req_tpc);
                end
            end
            ST_ACT: begin
                d.cnt = '0;
                d.st  = (q.rcd == 2'd0) ? ST_BURST : ST_WAIT;
            end
            ST_WAIT: begin
                if (q.cnt == CNT_W'(q.rcd) - CNT_W'(1)) begin
                    d.st  = ST_BURST;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_BURST: begin
                if (q.cnt == burst_last) begin
                    d.st  = ST_PRE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_PRE: begin
                if (q.cnt == CNT_W'(q.tpc) - CNT_W'(1))
                    d.st = ST_DONE;
                else
                    d.cnt = q.cnt + CNT_W'(1);
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.cl    <= 2'd1;
            q.tpc   <= 2'd1;
        end else begin
            q <= d;
        end
    end

    // ---- checks ----
    assert_ready_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sd_cs_n && !rd_valid));

    assert_act_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!sd_cs_n && !sd_ras_n && sd_cas_n && sd_we_n));

    assert_column_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_cas_n |-> (sd_ras_n && sd_we_n && !sd_cs_n));

    assert_strobe_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_bs_n |-> (sd_dqm == '0));

    assert_capture_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_bs_n |=> rd_valid);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (!rd_done && req_ready));

endmodule

// File: rtl/sdram_burst_rd.sv
module sdram_burst_rd #(
    parameter int ADDR_W     = 26,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int ROW_SHIFT  = 12,
    localparam int DQM_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_bus16,
    input  logic [1:0]        req_rcd,
    input  logic [1:0]        req_cl,
    input  logic [1:0]        req_tpc,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic [ADDR_W-1:0] sd_addr,
    input  logic [DATA_W-1:0] sd_dq,
    output logic              sd_bs_n,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_done
);

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int BEAT_W = OFF_W - 1;

    logic [BEAT_W-1:0] start_hi, cas_beat, dat_beat;
    logic [OFF_W-1:0]  cas_off, dat_off;
    logic              bus16;

    sdrb_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .LINE_BYTES(LINE_BYTES), .ROW_SHIFT(ROW_SHIFT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_bus16(req_bus16), .req_rcd(req_rcd), .req_cl(req_cl), .req_tpc(req_tpc),
        .start_hi(start_hi), .bus16(bus16), .cas_beat(cas_beat), .dat_beat(dat_beat),
        .cas_off(cas_off), .dat_off(dat_off),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_dqm(sd_dqm), .sd_addr(sd_addr), .sd_dq(sd_dq), .sd_bs_n(sd_bs_n),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .rd_done(rd_done)
    );

    // one offset generator for the column side, one for the capture side
    sdrb_wrap #(.LINE_BYTES(LINE_BYTES)) u_wrap_cas (
        .start_hi(start_hi), .bus16(bus16), .beat(cas_beat), .off(cas_off)
    );

    sdrb_wrap #(.LINE_BYTES(LINE_BYTES)) u_wrap_dat (
        .start_hi(start_hi), .bus16(bus16), .beat(dat_beat), .off(dat_off)
    );

endmodule

// File: tb/sim_sdram_burst_rd.sv
module sim_sdram_burst_rd;

    localparam int AW = 26;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_bus16 = 1'b0;
    logic [1:0]    req_rcd = '0, req_cl = '0, req_tpc = '0;
    logic          sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_bs_n;
    logic [3:0]    sd_dqm;
    logic [AW-1:0] sd_addr;
    logic [DW-1:0] sd_dq = '0;
    logic          rd_valid, rd_done;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    sdram_burst_rd u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_bus16(req_bus16), .req_rcd(req_rcd), .req_cl(req_cl), .req_tpc(req_tpc),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_dqm(sd_dqm), .sd_addr(sd_addr), .sd_dq(sd_dq), .sd_bs_n(sd_bs_n),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .rd_done(rd_done)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int beat_off(input logic [AW-1:0] a, input bit b16, input int i);
        if (b16) return ((int'(a[3:1]) + i) % 8) * 2;
        return ((int'(a[3:2]) + i) % 4) * 4;
    endfunction

    function automatic logic [31:0] pattern(input int seq, input int j);
        return (32'h1357_0000 * (seq + 1)) ^ (32'h0021_0000 * j) ^ (32'h0000_0F01 * (j + 3));
    endfunction

    // one full line fill, compared to a timeline derived from the request fields
    task automatic run_fill(input logic [AW-1:0] a, input bit b16,
                            input int rcd, input int cl, input int tpc, input int seq);
        int n  = b16 ? 8 : 4;
        int l  = (cl == 0) ? 1 : cl;
        int p  = (tpc == 0) ? 1 : tpc;
        int b  = 1 + rcd;
        int kd = b + n + l + p;
        @(negedge clk);
        chk("R2", "ready before request", req_ready, 1);
        req_valid = 1'b1; req_addr = a; req_bus16 = b16;
        req_rcd = 2'(rcd); req_cl = 2'(cl); req_tpc = 2'(tpc);
        @(posedge clk);
        for (int k = 0; k <= kd + 1; k++) begin
            bit e_ras, e_cas, e_we, e_bs, e_dqm0, e_vld;
            string tag;
            @(negedge clk);
            // R2: conflicting requests while busy must not disturb anything
            if (k < kd) begin
                req_valid = 1'b1; req_addr = ~a; req_bus16 = ~b16;
                req_rcd = 2'd3; req_cl = 2'd3; req_tpc = 2'd3;
            end else begin
                req_valid = 1'b0;
            end
            e_ras  = (k == 0) || (k == b + n + l);
            e_cas  = (k >= b) && (k < b + n);
            e_we   = (k == b + n + l);
            e_bs   = (k >= b + l) && (k < b + l + n);
            e_dqm0 = (k >= b) && (k < b + n + l);
            e_vld  = (k >= b + l + 1) && (k <= b + l + n);
            if (k == 0) tag = "R3";
            else if (k < b) tag = "R4";
            else if (k < b + n + l) tag = "R5";
            else if (k < kd) tag = "R10";
            else tag = "R11";
            chk(tag, "cs_n", sd_cs_n, (k < kd) ? 0 : 1);
            chk(tag, "ras_n", sd_ras_n, !e_ras);
            chk(tag, "cas_n", sd_cas_n, !e_cas);
            chk(tag, "we_n", sd_we_n, !e_we);
            if (k == 0) chk("R3", "row address", sd_addr, a >> 12);
            if (e_cas) chk("R6", "column address", sd_addr,
                           (a & 26'hFF0) | AW'(beat_off(a, b16, k - b)));
            chk("R8", "bs_n", sd_bs_n, !e_bs);
            chk("R8", "dqm", sd_dqm, e_dqm0 ? 4'h0 : 4'hF);
            chk("R7", "rd_valid", rd_valid, e_vld);
            if (e_vld) begin
                int j = k - b - l - 1;
                logic [31:0] pv = pattern(seq, j);
                chk("R6", "rd_addr", rd_addr, (a & ~26'hF) | AW'(beat_off(a, b16, j)));
                chk("R9", "rd_data", rd_data, b16 ? {16'h0, pv[15:0]} : pv);
            end
            chk("R11", "done", rd_done, k == kd);
            chk("R2", "ready", req_ready, k == kd + 1);
            // act as the memory: data only in the cycles it belongs to
            if (e_bs) sd_dq = pattern(seq, k - b - l);
            else      sd_dq = 32'hBAD0_0000 ^ DW'(k);
        end
    endtask

    task automatic finish_run;
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "ready", req_ready, 1);
        chk("R1", "cs_n", sd_cs_n, 1);
        chk("R1", "ras/cas/we", {sd_ras_n, sd_cas_n, sd_we_n}, 3'b111);
        chk("R1", "bs_n", sd_bs_n, 1);
        chk("R1", "dqm", sd_dqm, 4'hF);
        chk("R1", "rd_valid/done", {rd_valid, rd_done}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after release", {req_ready, sd_cs_n, rd_valid}, 3'b110);

        run_fill(26'h012_3450, 1'b0, 0, 0, 0, 0);   // aligned, all zero settings
        run_fill(26'h0AB_CDEC, 1'b0, 1, 2, 1, 1);   // miss on last word: wrap
        run_fill(26'h3FF_F006, 1'b1, 3, 3, 2, 2);   // 16-bit, mid-line start
        run_fill(26'h155_555E, 1'b1, 2, 1, 3, 3);   // 16-bit, last halfword
        run_fill(26'h200_0A08, 1'b0, 1, 3, 0, 4);   // 32-bit, third word
        run_fill(26'h000_0002, 1'b1, 0, 2, 1, 5);   // 16-bit, no row wait
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

endmodule